// File: doc/BRIEF.md
# Two-Level Address Translation Walker with Lookaside Buffer

This block turns 32-bit virtual addresses into physical addresses for one requester. Recent translations live in a small fully associative lookaside buffer. A hit answers in one cycle and touches no memory. On a miss, a hardware walker fetches descriptors from a two-level table in physical memory through a read port that allows only one outstanding read. A first-level descriptor can map a whole 1 MB section and end the walk after a single read. Otherwise it points at a second-level table of 4 KB pages, and the walk takes two reads.

Address mapping and access-rights checking are separate steps. The walk, or the buffer, supplies a frame and a two-bit rights code. The rights code is then tested against the privilege and direction of the current request. A request either returns a physical address or returns an abort, and the abort states whether the translation or the permission failed. Software sets the first-level table base by writing the base register. A write to that register, or a pulse on the flush input, empties the buffer.

Top module: `xlate_walker`

## Requirements
- R1: A request that hits in the lookaside buffer gets its response exactly one cycle after acceptance, and the block issues no memory read for it.
- R2: On a miss mapped by a page, the block makes two reads. The first-level descriptor is read at {base[31:14], VA[31:20], 2'b00}. The second-level descriptor is read at {L1[31:10], VA[19:12], 2'b00}. The result is {L2[31:12], VA[11:0]}.
- R3: A first-level descriptor with type bits [1:0] = 10 is a 1 MB section. The walk then ends after one read and returns {L1[31:20], VA[19:0]}.
- R4: Three descriptors are faults: a first-level type of 00 or 11, and a second-level descriptor with bits [1:0] = 00. Each gives abort kind 01 with a physical address of zero. A faulting walk is not cached, so a repeated request walks again.
- R5: Every completed walk writes its mapping and rights into the buffer, including a walk that then fails the rights check. Later requests in the same page, or anywhere in the same section, hit.
- R6: The rights code sits in L1[11:10] for a section and in L2[5:4] for a page. Code 00 denies all access. Code 01 allows privileged requests only. Code 10 allows reads at any privilege and denies writes. Code 11 allows everything. A denial gives abort kind 10 with a physical address of zero.
- R7: The base register keeps only bits [31:14] of the written value. `base_q` returns those bits with zeros below them. The register resets to zero.
- R8: A flush pulse or a base write empties the buffer, and `req_ready` is low in that cycle.
- R9: The buffer has 8 entries. It refills them in round-robin order, starting at slot 0 after reset or after it is emptied, so the ninth refill replaces the oldest entry.
- R10: Only one walk runs at a time. `req_ready` stays low from the cycle after a miss is accepted until the response cycle. While a memory read waits for `mem_req_ready`, its address stays unchanged.
- R11: After reset, `req_ready` = 1, `rsp_valid` = 0, `mem_req_valid` = 0 and `base_q` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_priv | input | 1 | 1 = privileged requester |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_pa | output | 32 | Physical address, zero on abort |
| rsp_abort_kind | output | 2 | 00 none, 01 translation fault, 10 permission fault |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| base_wr_en | input | 1 | Write the table base register |
| base_wr_data | input | 32 | New table base |
| base_q | output | 32 | Current table base, bits [13:0] zero |
| flush | input | 1 | Empty the lookaside buffer |

## Verification
On every cycle, the assertions check four things. A hit starts no read. A miss drops `req_ready` in the next cycle. A read held off by `mem_req_ready` keeps its address. A section stops after its first read. They also check that an emptied buffer holds no valid slot, that a refill marks its slot valid, and that every abort carries a zero address. Other behaviour only the bench scenarios can show. This covers the exact descriptor addresses, the physical address built from each descriptor type, and the rights decision for every code and privilege pairing. It also covers whether a fault is cached, which slot round-robin refill evicts, and how flushes and base writes lose the cached state.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int ADDR_W    = 32;
  localparam int BASE_LO   = 14;
  localparam int BASE_HI_W = ADDR_W - BASE_LO;
  localparam int VPN_W     = 20;
  localparam int TBL_HI_W  = 22;

  localparam logic [1:0] AK_NONE  = 2'b00;
  localparam logic [1:0] AK_XLATE = 2'b01;
  localparam logic [1:0] AK_PERM  = 2'b10;

  localparam logic [1:0] DT_FAULT = 2'b00;
  localparam logic [1:0] DT_TABLE = 2'b01;
  localparam logic [1:0] DT_SECT  = 2'b10;

  localparam logic [1:0] AP_NONE = 2'b00;
  localparam logic [1:0] AP_PRIV = 2'b01;
  localparam logic [1:0] AP_RO   = 2'b10;

  typedef struct packed {
    logic             sect;
    logic [VPN_W-1:0] vtag;
    logic [VPN_W-1:0] ptag;
    logic [1:0]       ap;
  } tlb_ent_t;

  function automatic logic [ADDR_W-1:0] l1_desc_addr(input logic [BASE_HI_W-1:0] base_hi,
                                                     input logic [ADDR_W-1:0] va);
    return {base_hi, va[31:20], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] l2_desc_addr(input logic [TBL_HI_W-1:0] tbl_hi,
                                                     input logic [ADDR_W-1:0] va);
    return {tbl_hi, va[19:12], 2'b00};
  endfunction

  function automatic logic perm_ok(input logic [1:0] ap, input logic priv, input logic wr);
    case (ap)
      AP_NONE: return 1'b0;
      AP_PRIV: return priv;
      AP_RO:   return !wr;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic entry_match(input tlb_ent_t e, input logic [VPN_W-1:0] vpn);
    if (e.sect) return e.vtag[19:8] == vpn[19:8];
    return e.vtag == vpn;
  endfunction

  function automatic logic [ADDR_W-1:0] entry_pa(input tlb_ent_t e, input logic [ADDR_W-1:0] va);
    if (e.sect) return {e.ptag[19:8], va[19:0]};
    return {e.ptag, va[11:0]};
  endfunction
endpackage

// File: rtl/xw_base_reg.sv
module xw_base_reg
  import xw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_data,
  output logic [BASE_HI_W-1:0] base_hi,
  output logic [ADDR_W-1:0]    base_full
);
  logic [BASE_HI_W-1:0] hi_q;
  logic                 unused_lo;

  assign unused_lo = ^wr_data[BASE_LO-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_q <= '0;
    else if (wr_en) hi_q <= wr_data[ADDR_W-1:BASE_LO];
  end

  assign base_hi   = hi_q;
  assign base_full = {hi_q, {BASE_LO{1'b0}}};
endmodule

// File: rtl/xw_tlb.sv
module xw_tlb
  import xw_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output tlb_ent_t         hit_ent,
  input  logic             clear,
  input  logic             wr_en,
  input  tlb_ent_t         wr_ent
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;
  tlb_ent_t           ent [ENTRIES];
  logic [IW-1:0]      rr;
  logic               fill_go;

  assign fill_go = wr_en && !clear;

  generate
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign match[gi] = vld[gi] && entry_match(ent[gi], lk_vpn);
    end
  endgenerate

  always_comb begin
    hit     = |match;
    hit_ent = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_ent = ent[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (clear) begin
      vld <= '0;
      rr  <= '0;
    end else if (wr_en) begin
      vld[rr] <= 1'b1;
      rr      <= (rr == LAST) ? '0 : rr + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) ent[rr] <= wr_ent;
  end

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld == '0));
  p_fill_marks_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> vld[$past(rr)]);
endmodule

// File: rtl/xw_walk_ctl.sv
module xw_walk_ctl
  import xw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    start_va,
  input  logic                 start_wr,
  input  logic                 start_priv,
  input  logic [BASE_HI_W-1:0] base_hi,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [ADDR_W-1:0]    mem_rsp_data,
  output logic                 idle,
  output logic                 done,
  output logic [1:0]           done_kind,
  output logic [ADDR_W-1:0]    done_pa,
  output logic                 fill_en,
  output tlb_ent_t             fill_ent
);
  typedef enum logic [2:0] {W_IDLE, W_L1_REQ, W_L1_WAIT, W_L2_REQ, W_L2_WAIT} wstate_e;

  wstate_e             st;
  logic [ADDR_W-1:0]   va_q;
  logic                wr_q;
  logic                priv_q;
  logic [TBL_HI_W-1:0] tbl_q;

  logic l1_rsp, l2_rsp, sect_end, tbl_step, l1_fault, l2_fault, page_end, xl_fault, granted;
  logic unused_bits;

  assign unused_bits = ^{mem_rsp_data[9:6], mem_rsp_data[3:2]};

  assign l1_rsp   = (st == W_L1_WAIT) && mem_rsp_valid;
  assign l2_rsp   = (st == W_L2_WAIT) && mem_rsp_valid;
  assign sect_end = l1_rsp && (mem_rsp_data[1:0] == DT_SECT);
  assign tbl_step = l1_rsp && (mem_rsp_data[1:0] == DT_TABLE);
  assign l1_fault = l1_rsp && !sect_end && !tbl_step;
  assign l2_fault = l2_rsp && (mem_rsp_data[1:0] == DT_FAULT);
  assign page_end = l2_rsp && !l2_fault;
  assign xl_fault = l1_fault || l2_fault;

  assign idle          = (st == W_IDLE);
  assign mem_req_valid = (st == W_L1_REQ) || (st == W_L2_REQ);
  assign mem_req_addr  = (st == W_L2_REQ) ? l2_desc_addr(tbl_q, va_q)
                                          : l1_desc_addr(base_hi, va_q);

  always_comb begin
    fill_ent.vtag = va_q[31:12];
    if (sect_end) begin
      fill_ent.sect = 1'b1;
      fill_ent.ptag = {mem_rsp_data[31:20], 8'h00};
      fill_ent.ap   = mem_rsp_data[11:10];
    end else begin
      fill_ent.sect = 1'b0;
      fill_ent.ptag = mem_rsp_data[31:12];
      fill_ent.ap   = mem_rsp_data[5:4];
    end
  end

  assign fill_en   = sect_end || page_end;
  assign done      = fill_en || xl_fault;
  assign granted   = perm_ok(fill_ent.ap, priv_q, wr_q);
  assign done_kind = xl_fault ? AK_XLATE : (granted ? AK_NONE : AK_PERM);
  assign done_pa   = (xl_fault || !granted) ? '0 : entry_pa(fill_ent, va_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      priv_q <= 1'b0;
      tbl_q  <= '0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          va_q   <= start_va;
          wr_q   <= start_wr;
          priv_q <= start_priv;
          st     <= W_L1_REQ;
        end
        W_L1_REQ: if (mem_req_ready) st <= W_L1_WAIT;
        W_L1_WAIT: begin
          if (tbl_step) begin
            tbl_q <= mem_rsp_data[31:10];
            st    <= W_L2_REQ;
          end else if (l1_rsp) begin
            st <= W_IDLE;
          end
        end
        W_L2_REQ:  if (mem_req_ready) st <= W_L2_WAIT;
        W_L2_WAIT: if (l2_rsp) st <= W_IDLE;
        default:   st <= W_IDLE;
      endcase
    end
  end

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_section_no_l2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sect_end |=> !mem_req_valid);
  p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xw_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_priv,
  output logic        rsp_valid,
  output logic [31:0] rsp_pa,
  output logic [1:0]  rsp_abort_kind,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        base_wr_en,
  input  logic [31:0] base_wr_data,
  output logic [31:0] base_q,
  input  logic        flush
);
  logic [BASE_HI_W-1:0] base_hi;
  logic                 tlb_clear, look_hit, req_fire, hit_fire, miss_fire;
  tlb_ent_t             hit_ent, fill_ent;
  logic                 walk_idle, walk_done, fill_en, hit_ok;
  logic [1:0]           walk_kind;
  logic [ADDR_W-1:0]    walk_pa;

  assign tlb_clear = flush || base_wr_en;
  assign req_ready = walk_idle && !tlb_clear;
  assign req_fire  = req_valid && req_ready;
  assign hit_fire  = req_fire && look_hit;
  assign miss_fire = req_fire && !look_hit;
  assign hit_ok    = perm_ok(hit_ent.ap, req_priv, req_write);

  xw_base_reg u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (base_wr_en),
    .wr_data   (base_wr_data),
    .base_hi   (base_hi),
    .base_full (base_q)
  );

  xw_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_vpn  (req_va[31:12]),
    .hit     (look_hit),
    .hit_ent (hit_ent),
    .clear   (tlb_clear),
    .wr_en   (fill_en),
    .wr_ent  (fill_ent)
  );

  xw_walk_ctl u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (miss_fire),
    .start_va      (req_va),
    .start_wr      (req_write),
    .start_priv    (req_priv),
    .base_hi       (base_hi),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .idle          (walk_idle),
    .done          (walk_done),
    .done_kind     (walk_kind),
    .done_pa       (walk_pa),
    .fill_en       (fill_en),
    .fill_ent      (fill_ent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_pa         <= '0;
      rsp_abort_kind <= AK_NONE;
    end else begin
      rsp_valid <= hit_fire || walk_done;
      if (hit_fire) begin
        rsp_pa         <= hit_ok ? entry_pa(hit_ent, req_va) : '0;
        rsp_abort_kind <= hit_ok ? AK_NONE : AK_PERM;
      end else if (walk_done) begin
        rsp_pa         <= walk_pa;
        rsp_abort_kind <= walk_kind;
      end
    end
  end

  p_hit_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> !mem_req_valid);
  p_miss_holds_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> !req_ready);
  p_abort_zero_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_abort_kind != AK_NONE) |-> (rsp_pa == '0));
  p_walk_starts_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> mem_req_valid);
endmodule

// File: tb/xlate_walker_bench.sv
module xlate_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [31:0] TB_BASE = 32'h0010_4000;
  localparam int NV = 24;

  // {va, write, priv, reads, kind}
  localparam logic [37:0] VEC [NV] = '{
    {32'h0040_3123, 1'b0, 1'b0, 2'd2, 2'd0},
    {32'h0040_3FFC, 1'b1, 1'b0, 2'd0, 2'd0},
    {32'h0350_1234, 1'b0, 1'b0, 2'd1, 2'd0},
    {32'h035F_FFF0, 1'b1, 1'b0, 2'd0, 2'd0},
    {32'h0150_0000, 1'b0, 1'b0, 2'd1, 2'd2},
    {32'h0150_0010, 1'b0, 1'b1, 2'd0, 2'd0},
    {32'h0150_0020, 1'b1, 1'b1, 2'd0, 2'd0},
    {32'h0250_0000, 1'b1, 1'b1, 2'd1, 2'd2},
    {32'h0250_0004, 1'b0, 1'b0, 2'd0, 2'd0},
    {32'h0050_0000, 1'b0, 1'b1, 2'd1, 2'd2},
    {32'h0060_0000, 1'b0, 1'b1, 2'd1, 2'd1},
    {32'h0060_0000, 1'b0, 1'b1, 2'd1, 2'd1},
    {32'h0070_0000, 1'b0, 1'b1, 2'd1, 2'd1},
    {32'h004F_F000, 1'b0, 1'b1, 2'd2, 2'd1},
    {32'h0040_1000, 1'b1, 1'b0, 2'd2, 2'd2},
    {32'h0040_1008, 1'b1, 1'b1, 2'd0, 2'd0},
    {32'h0040_2000, 1'b0, 1'b0, 2'd2, 2'd0},
    {32'h0040_2004, 1'b1, 1'b0, 2'd0, 2'd2},
    {32'h0040_0000, 1'b0, 1'b1, 2'd2, 2'd2},
    {32'h0080_5000, 1'b0, 1'b1, 2'd2, 2'd0},
    {32'h0040_3000, 1'b0, 1'b0, 2'd2, 2'd0},
    {32'h0350_0000, 1'b0, 1'b0, 2'd1, 2'd0},
    {32'h0250_0008, 1'b0, 1'b0, 2'd0, 2'd0},
    {32'h0080_5ABC, 1'b1, 1'b1, 2'd0, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_priv;
  logic        req_ready;
  logic [31:0] req_va;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_abort_kind;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        base_wr_en;
  logic [31:0] base_wr_data;
  logic [31:0] base_q;
  logic        flush;

  int n_cmp = 0;
  int n_bad = 0;
  int rd_count = 0;
  logic [31:0] addr_log [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_walker u_xlate_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_abort_kind(rsp_abort_kind),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .base_q(base_q),
    .flush(flush)
  );

  // Descriptor contents are generated from the address.
  function automatic logic [31:0] l1_word(input logic [11:0] idx);
    logic [31:0] tb;
    tb = 32'h0020_0000 + ({20'h0, idx} << 10);
    case (idx[1:0])
      2'd0:    return {tb[31:10], 8'h00, 2'b01};
      2'd1:    return {idx + 12'h100, 8'h00, idx[5:4], 8'h00, 2'b10};
      2'd2:    return 32'h0000_0AB0;
      default: return 32'h1234_5673;
    endcase
  endfunction

  function automatic logic [31:0] l2_word(input logic [31:0] a);
    logic [7:0]  p;
    logic [19:0] fr;
    p  = a[9:2];
    fr = a[29:10] ^ 20'hA5A5A;
    if (p == 8'hFF) return 32'h0000_0F30;
    return {fr, 6'h00, p[1:0], 2'b00, 2'b10};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a >= TB_BASE && a < TB_BASE + 32'h4000) return l1_word(a[13:2]);
    return l2_word(a);
  endfunction

  function automatic logic [31:0] ref_pa(input logic [31:0] va, input logic wr, input logic pv);
    logic [31:0] d1, d2;
    logic [1:0]  ap;
    logic [31:0] pa;
    d1 = l1_word(va[31:20]);
    if (d1[1:0] == 2'b10) begin
      pa = {d1[31:20], va[19:0]};
      ap = d1[11:10];
    end else if (d1[1:0] == 2'b01) begin
      d2 = l2_word({d1[31:10], va[19:12], 2'b00});
      if (d2[1:0] == 2'b00) return 32'h0;
      pa = {d2[31:12], va[11:0]};
      ap = d2[5:4];
    end else begin
      return 32'h0;
    end
    if ((ap == 2'b11) || (ap == 2'b01 && pv) || (ap == 2'b10 && !wr)) return pa;
    return 32'h0;
  endfunction

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory model: ready alternates, data two cycles after acceptance.
  initial begin
    logic       phase;
    int         lat;
    logic [31:0] pend;
    phase = 1'b0;
    lat = 0;
    pend = '0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(pend);
        end
      end
      phase = ~phase;
      mem_req_ready = phase;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        pend = mem_req_addr;
        addr_log[rd_count % 256] = mem_req_addr;
        rd_count++;
        lat = 2;
      end
    end
  end

  task automatic do_xact(input int idx, input logic [31:0] va, input logic wr, input logic pv,
                         input int exp_reads, input logic [1:0] exp_kind);
    int    r0, lat, guard;
    bit    ready_hi;
    string path, rtag;
    @(negedge clk);
    req_valid = 1'b1;
    req_va    = va;
    req_write = wr;
    req_priv  = pv;
    guard = 0;
    while (!req_ready && guard < 50) begin
      @(negedge clk);
      guard++;
    end
    r0 = rd_count;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    ready_hi = 1'b0;
    while (!rsp_valid && lat < 200) begin
      if (req_ready) ready_hi = 1'b1;
      @(negedge clk);
      lat++;
    end
    path = (exp_reads == 0) ? "R1" : (exp_reads == 1) ? "R3" : "R2";
    rtag = (idx >= 19 && idx <= 21) ? "R9" : (exp_reads == 0) ? "R5" : path;
    check_eq((exp_kind == 2'd1) ? "R4 kind" : (exp_kind == 2'd2) ? "R6 kind" : {path, " kind"},
             {30'h0, rsp_abort_kind}, {30'h0, exp_kind});
    check_eq((exp_kind == 2'd0) ? {path, " pa"} : "R6 pa", rsp_pa, ref_pa(va, wr, pv));
    check_eq({rtag, " reads"}, rd_count - r0, exp_reads);
    if (exp_reads == 0) check_eq("R1 latency", lat, 1);
    else                check_eq("R10 ready held low", {31'h0, ready_hi}, 32'h0);
    if (exp_reads >= 1)
      check_eq("R2 l1 addr", addr_log[r0 % 256], {TB_BASE[31:14], va[31:20], 2'b00});
    if (exp_reads == 2)
      check_eq("R2 l2 addr", addr_log[(r0 + 1) % 256],
               {l1_word(va[31:20]) >> 10, va[19:12], 2'b00});
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog: actual %0d cycles expected fewer", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_va = '0; req_write = 1'b0; req_priv = 1'b0;
    base_wr_en = 1'b0; base_wr_data = '0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check_eq("R11 req_ready", {31'h0, req_ready}, 32'h1);
    check_eq("R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check_eq("R11 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    check_eq("R11 base_q", base_q, 32'h0);

    // R7 base write drops low bits; R8 ready low during the write
    base_wr_en = 1'b1;
    base_wr_data = TB_BASE | 32'h0000_2ABC;
    #1 check_eq("R8 ready during base write", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    base_wr_en = 1'b0;
    check_eq("R7 base readback", base_q, TB_BASE);

    for (int i = 0; i < NV; i++) begin
      do_xact(i, VEC[i][37:6], VEC[i][5], VEC[i][4], int'(VEC[i][3:2]), VEC[i][1:0]);
    end

    // R8 flush empties buffer
    @(negedge clk);
    flush = 1'b1;
    #1 check_eq("R8 ready during flush", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    flush = 1'b0;
    do_xact(0, 32'h0250_0008, 1'b0, 1'b0, 1, 2'd0);

    // R8 base write also empties buffer
    @(negedge clk);
    base_wr_en = 1'b1;
    base_wr_data = TB_BASE;
    @(negedge clk);
    base_wr_en = 1'b0;
    do_xact(0, 32'h0250_000C, 1'b0, 1'b0, 1, 2'd0);
    // R5 refill covers the section again
    do_xact(0, 32'h025F_0000, 1'b0, 1'b0, 0, 2'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule